// File: doc/BRIEF.md
# Six-Channel Paired Down-Counter Timer

This block provides six down-counting timers that run on the core clock and are reached through a small 32-bit register bus: an address, a write strobe, write data and a combinational read-data return. The timers are grouped in three identical pairs. Each pair sits at its own 32-byte window, and the second timer of a pair is shifted by one word inside that window. Software programs a reload value, then starts the timer through its run register. It can also ask for an immediate load of the reload value into the counter. A running timer counts down once per clock. Each time it passes through zero it reloads and raises a pending flag.

Each pending flag is gated by an enable bit to form one interrupt line per timer. Software clears a pending flag by writing a 1 to its bit. A global clock-control register can freeze every counter at once, either by disabling the core or by keeping it in suspend. The registers remain readable and writable while the counters are frozen. A fixed identification register lets software confirm that the block is present.

Top module: `tmr_bank_unit`

## Requirements
- R1: Global registers sit at these offsets: clock control 0x00, identification 0x08, interrupt enable 0xF4, interrupt control 0xF8 and interrupt capture 0xFC. Timer t (0..5) has its registers at 0x10 + 0x20*(t/2) + 4*(t%2), plus 0x00 for control, 0x08 for run, 0x10 for reload and 0x18 for count.
- R2: The identification register always reads 0x0000_5900, which is the byte 0x59 in bits 15:8.
- R3: Clock control stores only bit 0 (disable), bit 4 (suspend release) and bit 8 (run-mode clock). All other bits read 0, and the register resets to 0.
- R4: A timer control register stores only bits 2, 7, 8 and 10. All other bits read 0.
- R5: Run register bit 0 is the start flag and reads back. Writing bit 2 as 1 copies the reload value into the counter on that clock edge. Bit 2 always reads 0.
- R6: A started timer with counting allowed decrements by 1 per clock. On a clock where it holds 0 it instead loads the reload value and sets its capture bit, so a reload value of 1 sets the capture bit every second clock.
- R7: While clock-control bit 0 is 1 or bit 4 is 0, no counter changes except by a load request, and all registers still accept reads and writes.
- R8: Writing 1 to a capture bit at 0xFC clears it. If an expiry and a clearing write hit the same bit on the same clock, the bit ends up set.
- R9: Interrupt output t is capture bit t ANDed with enable bit t, where bits 5:0 of 0xF4 are the enables.
- R10: Writing zero to a timer's run, control and reload registers stops its counter, and those three registers then read 0.
- R11: Unmapped offsets read 0 and ignore writes. The count register is read-only, counts are 16 bits wide, and reset leaves every register 0.
- R12: The interrupt control register stores bits 5:0, reads them back, and does not affect counting or interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 6 | One interrupt line per timer |

## Verification
Two events can fall on the same clock: a timer expiring, which sets its capture bit, and a software write that clears that bit. The bench runs a timer with reload value 1, so it expires on every second clock. It then issues clearing writes on several consecutive clocks, which makes both phases occur, including the one where the clear and the expiry coincide. The bench's behavioural model applies the clear first and the set second, and it compares the capture register and the interrupt lines on every clock. A second same-clock overlap, a load request arriving while the counter would otherwise tick or expire, is exercised by issuing load requests against running timers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // register kinds inside one timer slot; the value times 8 is the offset
  typedef enum logic [1:0] {
    RK_CTRL  = 2'd0,
    RK_RUN   = 2'd1,
    RK_RELD  = 2'd2,
    RK_COUNT = 2'd3
  } reg_kind_e;

  localparam logic [7:0] ID_BYTE     = 8'h59;
  localparam logic [7:0] OFF_CLKCTL  = 8'h00;
  localparam logic [7:0] OFF_IDENT   = 8'h08;
  localparam logic [7:0] OFF_IRQ_EN  = 8'hF4;
  localparam logic [7:0] OFF_IRQ_CTL = 8'hF8;
  localparam logic [7:0] OFF_IRQ_CAP = 8'hFC;

  localparam logic [31:0] CLKCTL_MASK = 32'h0000_0111;
  localparam logic [15:0] CTRL_MASK   = 16'h0584;

  // byte offset of timer t's register of kind k
  function automatic logic [7:0] slot_offset(int unsigned t, reg_kind_e k);
    int unsigned base;
    base = 32'h10 + 32'h20 * (t / 2) + 32'h4 * (t % 2) + 32'h8 * int'(k);
    return base[7:0];
  endfunction

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int N  = 6,
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  sel_ctrl,
  output logic [N-1:0]  sel_run,
  output logic [N-1:0]  sel_reld,
  output logic [N-1:0]  sel_count,
  output logic          sel_clkctl,
  output logic          sel_ident,
  output logic          sel_ien,
  output logic          sel_ictl,
  output logic          sel_cap,
  output logic          addr_hit
);

  for (genvar t = 0; t < N; t++) begin : g_slot
    assign sel_ctrl[t]  = (addr == AW'(slot_offset(t, RK_CTRL)));
    assign sel_run[t]   = (addr == AW'(slot_offset(t, RK_RUN)));
    assign sel_reld[t]  = (addr == AW'(slot_offset(t, RK_RELD)));
    assign sel_count[t] = (addr == AW'(slot_offset(t, RK_COUNT)));
  end

  assign sel_clkctl = (addr == AW'(OFF_CLKCTL));
  assign sel_ident  = (addr == AW'(OFF_IDENT));
  assign sel_ien    = (addr == AW'(OFF_IRQ_EN));
  assign sel_ictl   = (addr == AW'(OFF_IRQ_CTL));
  assign sel_cap    = (addr == AW'(OFF_IRQ_CAP));

  assign addr_hit = |{sel_ctrl, sel_run, sel_reld, sel_count,
                      sel_clkctl, sel_ident, sel_ien, sel_ictl, sel_cap};

  // R1: no offset may select two registers
  always_comb begin
    assert_sel_unique_R1: assert ($onehot0({sel_ctrl, sel_run, sel_reld, sel_count,
                                             sel_clkctl, sel_ident, sel_ien, sel_ictl, sel_cap}));
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_ctrl,
  input  logic             wr_run,
  input  logic             wr_reld,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] ctrl_o,
  output logic             run_o,
  output logic [CNT_W-1:0] reld_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] CMASK = CNT_W'(CTRL_MASK);

  logic [CNT_W-1:0] ctrl_q, reld_q, count_q;
  logic             run_q;
  logic             load_req;
  logic             tick;

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur,
                                                  logic [CNT_W-1:0] reld);
    return (cur == '0) ? reld : cur - 1'b1;
  endfunction

  assign load_req = wr_run & wdata[2];
  assign tick     = run_q & tick_en & ~load_req;
  assign expire_o = tick & (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      run_q   <= 1'b0;
      reld_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & CMASK;
      if (wr_run)  run_q  <= wdata[0];
      if (wr_reld) reld_q <= wdata;
      if (load_req)  count_q <= reld_q;
      else if (tick) count_q <= next_count(count_q, reld_q);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign run_o   = run_q;
  assign reld_o  = reld_q;
  assign count_o = count_q;

  // R7: a frozen core leaves the counter alone unless a load is requested
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_req) |=> $stable(count_q));

  // R10: a stopped timer does not count
  assert_stopped_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_req) |=> $stable(count_q));

  // R6: expiry reloads from the reload register
  assert_reload_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (count_q == $past(reld_q)));

  // R5: a load request copies the reload value
  assert_load_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (count_q == $past(reld_q)));

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ien,
  input  logic         wr_ictl,
  input  logic         wr_cap,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] expire,
  output logic [N-1:0] ien_o,
  output logic [N-1:0] ictl_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] irq_o
);

  logic [N-1:0] ien_q, ictl_q, pend_q;
  logic [N-1:0] clr_bits;

  assign clr_bits = wr_cap ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= '0;
      ictl_q <= '0;
      pend_q <= '0;
    end else begin
      if (wr_ien)  ien_q  <= wdata;
      if (wr_ictl) ictl_q <= wdata;
      pend_q <= (pend_q & ~clr_bits) | expire;
    end
  end

  assign ien_o  = ien_q;
  assign ictl_o = ictl_q;
  assign pend_o = pend_q;
  assign irq_o  = pend_q & ien_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8: the set from an expiry wins over a same-clock clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> pend_q[i]);
    // R8: a clear with no expiry leaves the bit low
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bits[i] && !expire[i]) |=> !pend_q[i]);
  end

endmodule

// File: rtl/tmr_bank_unit.sv
module tmr_bank_unit
  import tmr_pkg::*;
#(
  parameter int N     = 6,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [N-1:0]  irq_out
);

  logic [N-1:0] sel_ctrl, sel_run, sel_reld, sel_count;
  logic         sel_clkctl, sel_ident, sel_ien, sel_ictl, sel_cap, addr_hit;

  logic [DW-1:0]    clkctl_q;
  logic             tick_en;
  logic [CNT_W-1:0] ctrl_w  [N];
  logic [CNT_W-1:0] reld_w  [N];
  logic [CNT_W-1:0] count_w [N];
  logic [N-1:0]     run_w;
  logic [N-1:0]     expire_w;
  logic [N-1:0]     ien_w, ictl_w, pend_w;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:CNT_W];

  tmr_regdec #(.N(N), .AW(AW)) u_dec (
    .addr      (bus_addr),
    .sel_ctrl  (sel_ctrl),
    .sel_run   (sel_run),
    .sel_reld  (sel_reld),
    .sel_count (sel_count),
    .sel_clkctl(sel_clkctl),
    .sel_ident (sel_ident),
    .sel_ien   (sel_ien),
    .sel_ictl  (sel_ictl),
    .sel_cap   (sel_cap),
    .addr_hit  (addr_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    clkctl_q <= '0;
    else if (bus_we && sel_clkctl) clkctl_q <= bus_wdata & DW'(CLKCTL_MASK);
  end

  // counting needs the core enabled and out of suspend
  assign tick_en = ~clkctl_q[0] & clkctl_q[4];

  for (genvar t = 0; t < N; t++) begin : g_tmr
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_ctrl (bus_we & sel_ctrl[t]),
      .wr_run  (bus_we & sel_run[t]),
      .wr_reld (bus_we & sel_reld[t]),
      .wdata   (bus_wdata[CNT_W-1:0]),
      .ctrl_o  (ctrl_w[t]),
      .run_o   (run_w[t]),
      .reld_o  (reld_w[t]),
      .count_o (count_w[t]),
      .expire_o(expire_w[t])
    );
  end

  tmr_irq #(.N(N)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ien (bus_we & sel_ien),
    .wr_ictl(bus_we & sel_ictl),
    .wr_cap (bus_we & sel_cap),
    .wdata  (bus_wdata[N-1:0]),
    .expire (expire_w),
    .ien_o  (ien_w),
    .ictl_o (ictl_w),
    .pend_o (pend_w),
    .irq_o  (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_clkctl) bus_rdata = clkctl_q;
    if (sel_ident)  bus_rdata = DW'({ID_BYTE, 8'h00});
    if (sel_ien)    bus_rdata = DW'(ien_w);
    if (sel_ictl)   bus_rdata = DW'(ictl_w);
    if (sel_cap)    bus_rdata = DW'(pend_w);
    for (int t = 0; t < N; t++) begin
      if (sel_ctrl[t])  bus_rdata = DW'(ctrl_w[t]);
      if (sel_run[t])   bus_rdata = DW'(run_w[t]);
      if (sel_reld[t])  bus_rdata = DW'(reld_w[t]);
      if (sel_count[t]) bus_rdata = DW'(count_w[t]);
    end
  end

  assert_ident_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ident |-> (bus_rdata == DW'(32'h0000_5900)));

  assert_run_reqbit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel_run) |-> !bus_rdata[2]);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (bus_rdata == '0));

  assert_freeze_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en) |-> (expire_w == '0));

endmodule

// File: tb/sim_tmr_bank_unit.sv
`timescale 1ns/1ps
module sim_tmr_bank_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // behavioural reference state
  int m_clk, m_ien, m_ictl, m_pend;
  int m_con[6];
  int m_run[6];
  int m_rld[6];
  int m_cnt[6];

  always #2.5 clk = ~clk;

  tmr_bank_unit u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out)
  );

  function automatic int addr_of(int t, int kind);
    return 'h10 + 'h20 * (t / 2) + 4 * (t % 2) + 8 * kind;
  endfunction

  function automatic int model_read(int a);
    int v = 0;
    if (a == 'h00) v = m_clk;
    if (a == 'h08) v = 'h5900;
    if (a == 'hF4) v = m_ien;
    if (a == 'hF8) v = m_ictl;
    if (a == 'hFC) v = m_pend;
    for (int t = 0; t < 6; t++) begin
      if (a == addr_of(t, 0)) v = m_con[t];
      if (a == addr_of(t, 1)) v = m_run[t];
      if (a == addr_of(t, 2)) v = m_rld[t];
      if (a == addr_of(t, 3)) v = m_cnt[t];
    end
    return v;
  endfunction

  task automatic model_reset();
    m_clk = 0; m_ien = 0; m_ictl = 0; m_pend = 0;
    for (int t = 0; t < 6; t++) begin
      m_con[t] = 0; m_run[t] = 0; m_rld[t] = 0; m_cnt[t] = 0;
    end
  endtask

  task automatic model_clock(int a, bit we, int d);
    bit active;
    int expd = 0;
    int clr = 0;
    active = ((m_clk & 1) == 0) && (((m_clk >> 4) & 1) == 1);
    for (int t = 0; t < 6; t++) begin
      if (we && a == addr_of(t, 1) && ((d >> 2) & 1)) m_cnt[t] = m_rld[t];
      else if (m_run[t] != 0 && active) begin
        if (m_cnt[t] == 0) begin
          m_cnt[t] = m_rld[t];
          expd |= (1 << t);
        end else m_cnt[t] = m_cnt[t] - 1;
      end
    end
    if (we) begin
      if (a == 'h00) m_clk  = d & 'h111;
      if (a == 'hF4) m_ien  = d & 'h3F;
      if (a == 'hF8) m_ictl = d & 'h3F;
      if (a == 'hFC) clr    = d & 'h3F;
      for (int t = 0; t < 6; t++) begin
        if (a == addr_of(t, 0)) m_con[t] = d & 'h584;
        if (a == addr_of(t, 1)) m_run[t] = d & 1;
        if (a == addr_of(t, 2)) m_rld[t] = d & 'hFFFF;
      end
    end
    m_pend = (m_pend & ~clr) | expd;
  endtask

  // one bus cycle: drive after the falling edge, compare, then clock the model
  task automatic step(int a, bit we, int d, string tag);
    bus_addr  = 8'(a);
    bus_we    = we;
    bus_wdata = 32'(d);
    #1;
    vectors++;
    if (irq_out !== 6'(m_pend & m_ien)) begin
      fails++;
      $display("FAIL %s (R9) irq_out actual=%h expected=%h", tag, irq_out, 6'(m_pend & m_ien));
    end
    if (!we) begin
      vectors++;
      if (bus_rdata !== 32'(model_read(a))) begin
        fails++;
        $display("FAIL %s addr=%h rdata actual=%h expected=%h", tag, a[7:0], bus_rdata,
                 32'(model_read(a)));
      end
    end
    @(posedge clk);
    model_clock(a, we, d);
    @(negedge clk);
  endtask

  task automatic wr(int a, int d, string tag);
    step(a, 1'b1, d, tag);
  endtask

  task automatic rd(int a, string tag);
    step(a, 1'b0, 0, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) rd('hFC, tag);
  endtask

  task automatic read_all(string tag);
    rd('h00, tag); rd('h08, tag); rd('hF4, tag); rd('hF8, tag); rd('hFC, tag);
    for (int t = 0; t < 6; t++)
      for (int k = 0; k < 4; k++) rd(addr_of(t, k), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired before the sequence completed");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state, R1 map, R2 identification
    read_all("R11_reset");
    rd('h08, "R2_ident");
    rd('h04, "R11_unmapped"); rd('h0C, "R11_unmapped");
    rd('h80, "R11_unmapped"); rd('hF0, "R11_unmapped");
    wr('h0C, 'hFFFF_FFFF, "R11_unmapped_wr");
    wr('hF0, 'hFFFF_FFFF, "R11_unmapped_wr");
    read_all("R11_after_unmapped_wr");

    // R3 clock control masking
    wr('h00, 'hFFFF_FFFF, "R3_clkctl");
    rd('h00, "R3_clkctl");

    // R4 control masking at every timer, R1 placement
    for (int t = 0; t < 6; t++) wr(addr_of(t, 0), 'hFFFF_FFFF, "R4_ctrl");
    for (int t = 0; t < 6; t++) wr(addr_of(t, 2), 'h10 + 3 * t, "R1_reload");
    read_all("R1_map");

    // R11 count is read-only
    wr(addr_of(2, 3), 'h1234, "R11_count_ro");
    rd(addr_of(2, 3), "R11_count_ro");

    // R12 interrupt control stores and has no effect
    wr('hF8, 'hFFFF_FFEA, "R12_ictl");
    rd('hF8, "R12_ictl");

    // R5 load request while frozen (R7): core disabled here
    wr(addr_of(0, 1), 'h4, "R5_load_frozen");
    rd(addr_of(0, 3), "R5_load_frozen");
    rd(addr_of(0, 1), "R5_reqbit_zero");

    // enable counting; R6 timer 0 with reload 1
    wr('h00, 'h110, "R3_run");
    wr('hF4, 'h3F, "R9_enable");
    wr(addr_of(0, 2), 1, "R6_reload1");
    wr(addr_of(0, 1), 'h5, "R6_start");
    for (int i = 0; i < 8; i++) rd(addr_of(0, 3), "R6_every_other");

    // R8 clearing writes on consecutive clocks, both phases against expiry
    for (int i = 0; i < 6; i++) wr('hFC, 'h01, "R8_set_vs_clear");
    idle(3, "R8_after");

    // R9 gating by enable
    wr('hF4, 'h00, "R9_disable");
    idle(4, "R9_masked");
    wr('hF4, 'h15, "R9_partial");

    // start all timers with staggered reloads
    for (int t = 1; t < 6; t++) begin
      wr(addr_of(t, 2), t + 2, "R6_reload");
      wr(addr_of(t, 1), 'h5, "R6_start");
    end
    for (int i = 0; i < 20; i++) begin
      rd(addr_of(i % 6, 3), "R6_count");
      if (i % 5 == 4) wr('hFC, 'h3F, "R8_clear_all");
    end

    // R7 freeze by disable bit, then by suspend, then resume
    wr('h00, 'h111, "R7_disable");
    for (int t = 0; t < 6; t++) rd(addr_of(t, 3), "R7_frozen");
    wr(addr_of(3, 2), 'h7, "R7_regs_live");
    rd(addr_of(3, 2), "R7_regs_live");
    wr('h00, 'h100, "R7_suspend");
    for (int t = 0; t < 6; t++) rd(addr_of(t, 3), "R7_suspended");
    wr('h00, 'h110, "R7_resume");
    for (int i = 0; i < 12; i++) rd(addr_of(3, 3), "R7_resumed");

    // R5 load request on a running timer
    wr(addr_of(4, 2), 'h40, "R5_reload");
    wr(addr_of(4, 1), 'h5, "R5_load_running");
    rd(addr_of(4, 3), "R5_load_running");
    idle(3, "R5_after");

    // R10 stop and clear timer 5
    wr(addr_of(5, 1), 0, "R10_stop");
    wr(addr_of(5, 0), 0, "R10_stop");
    wr(addr_of(5, 2), 0, "R10_stop");
    for (int k = 0; k < 4; k++) rd(addr_of(5, k), "R10_cleared");
    idle(6, "R10_idle");
    rd(addr_of(5, 3), "R10_still");

    wr('hFC, 'h3F, "R8_final_clear");
    idle(10, "R6_tail");
    read_all("R1_final");

    finish_run();
  end

endmodule